// File: doc/BRIEF.md
# NAND Interface Timing Calculator

This block turns a set of asynchronous NAND flash timing limits, each given in picoseconds, into the cycle counts and flags that a flash controller loads into its timing and control registers. From the minimum read cycle time it picks one of three interface clock rates and a write-strobe delay option. It then derives the address setup, data setup, data hold and busy-timeout cycle counts for that clock. Last, it works out how far the read sample strobe must be delayed, in eighth-period steps of a reference period, so that data from an extended-data-out device is captured after the read strobe has already risen.

Firmware or a bring-up sequencer loads the timing limits, pulses `start_i` while `busy_o` is low, and waits for `done_o`. All results change together in the `done_o` cycle and stay fixed until the next accepted start. When the sample delay is in use, the block keeps `busy_o` high and raises `settle_o` for a fixed number of cycles, so that the delay line can lock before the controller uses it. Every quotient comes from a single shared restoring divider that the calculation steps take in turn.

Top module: `nand_tcalc`

## Requirements
- R1: A read cycle minimum of at least 30000 ps selects the slow rate (`rate_o` = 0, 22 MHz) and sets `wsd_o` = 1, the 4-to-8 ns write-strobe delay. At least 25000 ps selects the mid rate (`rate_o` = 1, 80 MHz). Anything lower selects the fast rate (`rate_o` = 2, 100 MHz). The two faster rates both give `wsd_o` = 0.
- R2: `period_o` is 10^12 divided by the chosen rate in Hz, truncated: 45454, 12500 or 10000 ps.
- R3: The address setup, data setup and data hold outputs are each the timing limit divided by the period and rounded up. Each output carries the low `CNT_W` bits of its count.
- R4: `busy_cnt_o` is the low `BUSY_W` bits of ceil((busy max + read busy max) / period). `busy_field_o` is that value shifted left by 12 bits, which equals multiplying it by 4096.
- R5: The reference period is half the clock period, truncated, when the clock period is strictly greater than the chain threshold. Otherwise it equals the clock period. A threshold input of 0 selects the default of 12000 ps.
- R6: With N = (read access max + 4000 − data_setup_count × period) × 8, and using the full data setup count, `sample_dly_o` is the low `SDLY_W` bits of floor(N / reference period) when N > 0, and 0 otherwise.
- R7: `dll_en_o` is 1 exactly when `sample_dly_o` is nonzero. `half_period_o` is 1 only when the reference period was halved and `dll_en_o` is 1.
- R8: When `dll_en_o` is set, `settle_o` is high for exactly `SETTLE_CYC` (64) consecutive cycles. These cycles start in the `done_o` cycle, and `busy_o` falls in the cycle after the last of them. When `dll_en_o` is clear, `settle_o` stays low and `busy_o` is already low in the `done_o` cycle.
- R9: Each accepted start gives exactly one `done_o` pulse, which lasts one cycle. Result outputs change only in the `done_o` cycle.
- R10: A start pulse while `busy_o` is high is ignored. Inputs are captured at the accepted start, so later input changes do not affect the result.
- R11: After reset, `busy_o`, `done_o`, `settle_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calculation when idle |
| trc_min_i | input | PS_W | Minimum read cycle time, ps |
| tals_i | input | PS_W | Address setup minimum, ps |
| tds_i | input | PS_W | Data setup minimum, ps |
| tdh_i | input | PS_W | Data hold minimum, ps |
| trea_i | input | PS_W | Read access maximum, ps |
| twb_i | input | PS_W | Busy maximum, ps |
| tr_i | input | PS_W | Read busy maximum, ps |
| chain_thr_i | input | PS_W | Chain delay threshold, ps (0 selects the default) |
| busy_o | output | 1 | Calculation or settle wait in progress |
| done_o | output | 1 | One-cycle pulse when results update |
| settle_o | output | 1 | Delay line settle wait |
| rate_o | output | 2 | Clock rate code: 0 slow, 1 mid, 2 fast |
| wsd_o | output | 1 | Write-strobe delay option |
| period_o | output | PS_W | Clock period, ps |
| addr_setup_o | output | CNT_W | Address setup cycles |
| data_setup_o | output | CNT_W | Data setup cycles |
| data_hold_o | output | CNT_W | Data hold cycles |
| busy_cnt_o | output | BUSY_W | Busy timeout cycles |
| busy_field_o | output | BUSY_W+12 | Busy timeout cycles times 4096 |
| sample_dly_o | output | SDLY_W | Sample delay factor |
| half_period_o | output | 1 | Reference period halved |
| dll_en_o | output | 1 | Delay line enable |

## Verification
Two events fall in the same cycle. When the sample delay is nonzero, the `done_o` pulse and the first cycle of `settle_o` coincide, and a restart can be attempted while the wait is still running. The scoreboard counts the cycles in which `settle_o` is high while `busy_o` stays high, starting at the `done_o` cycle. It expects exactly 64 when the delay is in use and 0 when it is not, which also confirms that `busy_o` falls right after the wait ends. It then issues a start with different inputs in the middle of a wait. It confirms that no extra `done_o` pulse appears and that the results still match the first set of inputs.

// File: rtl/nand_tcalc_pkg.sv
package nand_tcalc_pkg;
  typedef enum logic [1:0] {RATE_SLOW = 2'd0, RATE_MID = 2'd1, RATE_FAST = 2'd2} rate_e;
  typedef enum logic [2:0] {OP_ALS, OP_DS, OP_DH, OP_BSY, OP_SDLY} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_KICK, ST_WAIT, ST_SETTLE} st_e;

  localparam longint unsigned PS_PER_SEC = 64'd1_000_000_000_000;

  function automatic longint unsigned period_ps(input longint unsigned hz);
    return PS_PER_SEC / hz;
  endfunction
endpackage

// File: rtl/nand_tcalc_mode.sv
module nand_tcalc_mode
  import nand_tcalc_pkg::*;
#(
  parameter int          PS_W        = 32,
  parameter int unsigned SLOW_HZ     = 22_000_000,
  parameter int unsigned MID_HZ      = 80_000_000,
  parameter int unsigned FAST_HZ     = 100_000_000,
  parameter int unsigned TRC_SLOW_PS = 30000,
  parameter int unsigned TRC_MID_PS  = 25000
) (
  input  logic [PS_W-1:0] trc_i,
  input  logic [PS_W-1:0] thr_i,
  output rate_e           rate_o,
  output logic            wsd_o,
  output logic [PS_W-1:0] period_o,
  output logic [PS_W-1:0] refp_o,
  output logic            half_o
);
  localparam logic [PS_W-1:0] PER_SLOW = PS_W'(period_ps(64'(SLOW_HZ)));
  localparam logic [PS_W-1:0] PER_MID  = PS_W'(period_ps(64'(MID_HZ)));
  localparam logic [PS_W-1:0] PER_FAST = PS_W'(period_ps(64'(FAST_HZ)));

  always_comb begin
    if (trc_i >= PS_W'(TRC_SLOW_PS)) begin
      rate_o   = RATE_SLOW;
      wsd_o    = 1'b1;
      period_o = PER_SLOW;
    end else if (trc_i >= PS_W'(TRC_MID_PS)) begin
      rate_o   = RATE_MID;
      wsd_o    = 1'b0;
      period_o = PER_MID;
    end else begin
      rate_o   = RATE_FAST;
      wsd_o    = 1'b0;
      period_o = PER_FAST;
    end
    half_o = period_o > thr_i;
    refp_o = half_o ? (period_o >> 1) : period_o;
  end
endmodule

// File: rtl/nand_tcalc_div.sv
module nand_tcalc_div #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  q_q, r_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    r_sh, r_nx;
  logic          ge;

  always_comb begin
    r_sh = {r_q, q_q[W-1]};
    ge   = r_sh >= {1'b0, dvs_q};
    r_nx = ge ? (r_sh - {1'b0, dvs_q}) : r_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !run_q) begin
        q_q   <= dvd_i;
        r_q   <= '0;
        dvs_q <= dvs_i;
        dvd_q <= dvd_i;
        cnt_q <= CW'(W - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q <= {q_q[W-2:0], ge};
        r_q <= r_nx[W-1:0];
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign quot_o = q_q;

  logic [2*W-1:0] prod, dvd_x, dvs_x;
  assign prod  = (2*W)'(quot_o) * (2*W)'(dvs_q);
  assign dvd_x = (2*W)'(dvd_q);
  assign dvs_x = (2*W)'(dvs_q);

  // R3: quotient is the floor of dividend/divisor
  a_r3_div_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prod <= dvd_x) && ((dvd_x - prod) < dvs_x));
endmodule

// File: rtl/nand_tcalc_settle.sv
module nand_tcalc_settle #(
  parameter int CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic last_o
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else if (start_i && !active_o) begin
      cnt_q    <= CW'(CYC - 1);
      active_o <= 1'b1;
    end else if (active_o) begin
      if (cnt_q == '0) active_o <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign last_o = active_o && (cnt_q == '0);

  logic [CW:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (active_o) len_q <= len_q + 1'b1;
    else               len_q <= '0;
  end

  // R8: wait window is exactly CYC cycles long
  a_r8_settle_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> len_q == (CW+1)'(CYC));
  a_r8_settle_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(start_i));
endmodule

// File: rtl/nand_tcalc.sv
module nand_tcalc
  import nand_tcalc_pkg::*;
#(
  parameter int          PS_W        = 32,
  parameter int          CNT_W       = 8,
  parameter int          BUSY_W      = 16,
  parameter int          SDLY_W      = 8,
  parameter int          SETTLE_CYC  = 64,
  parameter int unsigned SLOW_HZ     = 22_000_000,
  parameter int unsigned MID_HZ      = 80_000_000,
  parameter int unsigned FAST_HZ     = 100_000_000,
  parameter int unsigned TRC_SLOW_PS = 30000,
  parameter int unsigned TRC_MID_PS  = 25000,
  parameter int unsigned MARGIN_PS   = 4000,
  parameter int unsigned DEF_THR_PS  = 12000,
  parameter int          BUSY_SHIFT  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [PS_W-1:0]          trc_min_i,
  input  logic [PS_W-1:0]          tals_i,
  input  logic [PS_W-1:0]          tds_i,
  input  logic [PS_W-1:0]          tdh_i,
  input  logic [PS_W-1:0]          trea_i,
  input  logic [PS_W-1:0]          twb_i,
  input  logic [PS_W-1:0]          tr_i,
  input  logic [PS_W-1:0]          chain_thr_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     settle_o,
  output logic [1:0]               rate_o,
  output logic                     wsd_o,
  output logic [PS_W-1:0]          period_o,
  output logic [CNT_W-1:0]         addr_setup_o,
  output logic [CNT_W-1:0]         data_setup_o,
  output logic [CNT_W-1:0]         data_hold_o,
  output logic [BUSY_W-1:0]        busy_cnt_o,
  output logic [BUSY_W+BUSY_SHIFT-1:0] busy_field_o,
  output logic [SDLY_W-1:0]        sample_dly_o,
  output logic                     half_period_o,
  output logic                     dll_en_o
);
  localparam int DW = PS_W + 4;
  localparam int PW = DW + PS_W + 2;

  st_e st_q;
  op_e op_q;

  logic [PS_W-1:0]  trc_q, thr_q, tals_q, tds_q, tdh_q, trea_q;
  logic [PS_W:0]    tbsy_q;
  logic [CNT_W-1:0] als_q, dh_q;
  logic [DW-1:0]    ds_q;
  logic [BUSY_W-1:0] bsy_q;

  rate_e           rate_w;
  logic            wsd_w, half_w;
  logic [PS_W-1:0] per_w, refp_w;

  nand_tcalc_mode #(
    .PS_W(PS_W), .SLOW_HZ(SLOW_HZ), .MID_HZ(MID_HZ), .FAST_HZ(FAST_HZ),
    .TRC_SLOW_PS(TRC_SLOW_PS), .TRC_MID_PS(TRC_MID_PS)
  ) u_mode (
    .trc_i(trc_q), .thr_i(thr_q), .rate_o(rate_w), .wsd_o(wsd_w),
    .period_o(per_w), .refp_o(refp_w), .half_o(half_w)
  );

  // signed sample-delay numerator, in eighth steps
  logic [PW-1:0] rp_w, num_w, num8_w;
  logic          num_pos;
  always_comb begin
    rp_w    = PW'(ds_q) * PW'(per_w);
    num_w   = PW'(trea_q) + PW'(MARGIN_PS) - rp_w;
    num8_w  = num_w << 3;
    num_pos = !num8_w[PW-1] && (num8_w != '0);
  end

  logic [DW-1:0] per_x, dvd_w, dvs_w, quot_w;
  logic          div_start, div_done;

  always_comb begin
    per_x = DW'(per_w);
    dvs_w = per_x;
    unique case (op_q)
      OP_ALS:  dvd_w = DW'(tals_q) + per_x - DW'(1);
      OP_DS:   dvd_w = DW'(tds_q)  + per_x - DW'(1);
      OP_DH:   dvd_w = DW'(tdh_q)  + per_x - DW'(1);
      OP_BSY:  dvd_w = DW'(tbsy_q) + per_x - DW'(1);
      default: begin
        dvd_w = num8_w[DW-1:0];
        dvs_w = DW'(refp_w);
      end
    endcase
  end

  logic skip_sdly;
  assign skip_sdly = (op_q == OP_SDLY) && !num_pos;
  assign div_start = (st_q == ST_KICK) && !skip_sdly;

  nand_tcalc_div #(.W(DW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .dvd_i(dvd_w), .dvs_i(dvs_w), .done_o(div_done), .quot_o(quot_w)
  );

  logic              fin;
  logic [SDLY_W-1:0] fac_w;
  logic              dll_w;
  always_comb begin
    fin   = ((st_q == ST_KICK) && skip_sdly) ||
            ((st_q == ST_WAIT) && div_done && (op_q == OP_SDLY));
    fac_w = (st_q == ST_WAIT) ? quot_w[SDLY_W-1:0] : '0;
    dll_w = fac_w != '0;
  end

  logic settle_last;
  nand_tcalc_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(fin && dll_w),
    .active_o(settle_o), .last_o(settle_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_ALS;
      trc_q  <= '0;
      thr_q  <= '0;
      tals_q <= '0;
      tds_q  <= '0;
      tdh_q  <= '0;
      trea_q <= '0;
      tbsy_q <= '0;
      als_q  <= '0;
      ds_q   <= '0;
      dh_q   <= '0;
      bsy_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          trc_q  <= trc_min_i;
          thr_q  <= (chain_thr_i == '0) ? PS_W'(DEF_THR_PS) : chain_thr_i;
          tals_q <= tals_i;
          tds_q  <= tds_i;
          tdh_q  <= tdh_i;
          trea_q <= trea_i;
          tbsy_q <= {1'b0, twb_i} + {1'b0, tr_i};
          op_q   <= OP_ALS;
          st_q   <= ST_KICK;
        end
        ST_KICK: begin
          if (skip_sdly) st_q <= ST_IDLE;
          else           st_q <= ST_WAIT;
        end
        ST_WAIT: if (div_done) begin
          unique case (op_q)
            OP_ALS:  als_q <= quot_w[CNT_W-1:0];
            OP_DS:   ds_q  <= quot_w;
            OP_DH:   dh_q  <= quot_w[CNT_W-1:0];
            OP_BSY:  bsy_q <= quot_w[BUSY_W-1:0];
            default: ;
          endcase
          if (op_q == OP_SDLY) st_q <= dll_w ? ST_SETTLE : ST_IDLE;
          else begin
            op_q <= op_e'(op_q + 3'd1);
            st_q <= ST_KICK;
          end
        end
        ST_SETTLE: if (settle_last) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      rate_o        <= '0;
      wsd_o         <= 1'b0;
      period_o      <= '0;
      addr_setup_o  <= '0;
      data_setup_o  <= '0;
      data_hold_o   <= '0;
      busy_cnt_o    <= '0;
      busy_field_o  <= '0;
      sample_dly_o  <= '0;
      half_period_o <= 1'b0;
      dll_en_o      <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        rate_o        <= rate_w;
        wsd_o         <= wsd_w;
        period_o      <= per_w;
        addr_setup_o  <= als_q;
        data_setup_o  <= ds_q[CNT_W-1:0];
        data_hold_o   <= dh_q;
        busy_cnt_o    <= bsy_q;
        busy_field_o  <= {bsy_q, {BUSY_SHIFT{1'b0}}};
        sample_dly_o  <= fac_w;
        half_period_o <= half_w && dll_w;
        dll_en_o      <= dll_w;
      end
    end
  end

  assign busy_o = st_q != ST_IDLE;

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sample_dly_o) && $stable(addr_setup_o) &&
                $stable(busy_cnt_o) && $stable(dll_en_o) && $stable(rate_o));
  a_r7_half_needs_dll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_period_o |-> dll_en_o);
  a_r1_wsd_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wsd_o |-> rate_o == 2'd0);
  a_r10_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r8_settle_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |-> busy_o);
endmodule

// File: tb/sim_nand_tcalc.sv
module sim_nand_tcalc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] trc = '0, tals = '0, tds = '0, tdh = '0, trea = '0, twb = '0, tr = '0, thr = '0;

  logic        busy, done, settle, wsd, half, dll;
  logic [1:0]  rate;
  logic [31:0] period;
  logic [7:0]  als, ds, dh, sdly;
  logic [15:0] bcnt;
  logic [27:0] bfld;

  always #5 clk = ~clk;

  nand_tcalc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .trc_min_i(trc), .tals_i(tals), .tds_i(tds), .tdh_i(tdh), .trea_i(trea),
    .twb_i(twb), .tr_i(tr), .chain_thr_i(thr),
    .busy_o(busy), .done_o(done), .settle_o(settle), .rate_o(rate), .wsd_o(wsd),
    .period_o(period), .addr_setup_o(als), .data_setup_o(ds), .data_hold_o(dh),
    .busy_cnt_o(bcnt), .busy_field_o(bfld), .sample_dly_o(sdly),
    .half_period_o(half), .dll_en_o(dll)
  );

  typedef struct {
    longint rate, wsd, per, als, ds, dh, bcnt, bfld, sdly, half, dll, settle;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, n_push = 0, n_done = 0;
  bit timeout = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input longint c_trc, c_als, c_ds, c_dh, c_rea, c_wb, c_r, c_thr);
    exp_t e;
    longint thr_e, refp, dsf, num, f;
    bit hf;
    thr_e = (c_thr == 0) ? 12000 : c_thr;
    if (c_trc >= 30000) begin e.rate = 0; e.wsd = 1; e.per = 64'd1000000000000 / 22000000; end
    else if (c_trc >= 25000) begin e.rate = 1; e.wsd = 0; e.per = 64'd1000000000000 / 80000000; end
    else begin e.rate = 2; e.wsd = 0; e.per = 64'd1000000000000 / 100000000; end
    hf   = e.per > thr_e;
    refp = hf ? e.per / 2 : e.per;
    e.als = ((c_als + e.per - 1) / e.per) & 255;
    dsf   = (c_ds + e.per - 1) / e.per;
    e.ds  = dsf & 255;
    e.dh  = ((c_dh + e.per - 1) / e.per) & 255;
    e.bcnt = ((c_wb + c_r + e.per - 1) / e.per) & 65535;
    e.bfld = e.bcnt * 4096;
    num = (c_rea + 4000 - dsf * e.per) * 8;
    f = (num > 0) ? (num / refp) & 255 : 0;
    e.sdly = f;
    e.dll  = (f != 0) ? 1 : 0;
    e.half = (hf && f != 0) ? 1 : 0;
    e.settle = (f != 0) ? 64 : 0;
    while (busy) @(negedge clk);
    trc = 32'(c_trc); tals = 32'(c_als); tds = 32'(c_ds); tdh = 32'(c_dh);
    trea = 32'(c_rea); twb = 32'(c_wb); tr = 32'(c_r); thr = 32'(c_thr);
    q.push_back(e);
    n_push++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        int n;
        n_done++;
        if (q.size() == 0) check("R9 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          check("R1 rate", rate, e.rate);
          check("R1 wsd", wsd, e.wsd);
          check("R2 period", period, e.per);
          check("R3 addr", als, e.als);
          check("R3 dsetup", ds, e.ds);
          check("R3 dhold", dh, e.dh);
          check("R4 busy cnt", bcnt, e.bcnt);
          check("R4 busy field", bfld, e.bfld);
          check("R6 sample dly", sdly, e.sdly);
          check("R5 half", half, e.half);
          check("R7 dll", dll, e.dll);
          n = 0;
          while (busy) begin
            if (settle) n++;
            @(negedge clk);
          end
          check("R8 settle len", n, e.settle);
          check("R8 settle low after", settle, 0);
          check("R9 held sdly", sdly, e.sdly);
          check("R9 held addr", als, e.als);
        end
      end
    end
  end

  task automatic run_all;
    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 settle", settle, 0);
    check("R11 sdly", sdly, 0);
    check("R11 dll", dll, 0);
    check("R11 period", period, 0);
    // fast rate, plain
    run_case(20000, 10000, 7000, 5000, 16000, 100000, 200000000, 0);
    // mid rate, default threshold halves the reference
    run_case(25000, 10000, 10000, 5000, 20000, 100000, 25000000, 0);
    // slow rate, negative numerator
    run_case(100000, 50000, 40000, 20000, 40000, 100000, 25000000, 0);
    // rate boundaries
    run_case(30000, 10000, 10000, 5000, 20000, 100000, 25000000, 0);
    run_case(29999, 10000, 10000, 5000, 20000, 100000, 25000000, 0);
    run_case(24999, 10000, 10000, 5000, 20000, 100000, 25000000, 0);
    // period equal to threshold: no halving (R5)
    run_case(25000, 10000, 10000, 5000, 20000, 100000, 25000000, 12500);
    // numerator exactly zero (R6)
    run_case(20000, 10000, 7000, 5000, 6000, 100000, 25000000, 0);
    // multi-cycle data setup
    run_case(20000, 25001, 25000, 19999, 30000, 100000, 25000000, 0);
    // busy count truncation (R4)
    run_case(20000, 10000, 7000, 5000, 16000, 100000, 1000000000, 0);
    // R10: start during the settle wait is ignored, inputs captured
    run_case(20000, 10000, 7000, 5000, 16000, 100000, 200000000, 0);
    repeat (80) begin
      if (busy) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R10 busy during wait", busy, 1);
    trc = 32'd100000; tals = 32'd90000; trea = 32'd90000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R10 done count", n_done, n_push);
    check("R10 idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule